// File: doc/BRIEF.md
# Timer-Paced Sample FIFO Channel

This block plays back signed 8-bit audio samples for two streaming channels. Each channel owns a byte FIFO that a register bus fills 16 bits at a time. Every write to a FIFO address places two samples in the queue, the low byte first and then the high byte. The channels do not wait for a consumer handshake. Each one follows one of two external timer overflow pulses. On each overflow from its chosen timer, a channel moves one sample into a held output register. After that pop, if the queue has run low, the channel sends a one-cycle refill request to the DMA controller.

A shared control register sets, for each channel, the timer choice, the left and right routing enables and a volume bit. It also has a write-one bit per channel that empties that channel's FIFO. A master enable sits in a separate register and is always writable. While it is clear, the block ignores timer overflows and every other register write. The DMA engine, the timers and the mixer that uses the samples, routing and volume outputs are outside this block.

Top module: `timer_sample_chan`

## Requirements
- R1: A write to address 0 always loads the master enable from data bit 7. Reading address 0 returns the master enable in bit 7 and zero in all other bits.
- R2: While the master enable is clear, the block ignores timer overflows and writes to addresses 1 through 5. The samples, the refill outputs, the stored control bits and the FIFO contents all stay unchanged.
- R3: Address 1 is the control register. For channel A (index 0) the fields are: bit 2 volume, bit 8 right enable, bit 9 left enable, bit 10 timer select. Channel B (index 1) uses bits 3, 12, 13 and 14 for the same fields. Reading address 1 returns only these stored bits. Bits 11 and 15 always read as zero.
- R4: A write to address 2 or 3 pushes into FIFO A, and a write to address 4 or 5 pushes into FIFO B. Each write enqueues data bits 7:0 first and then bits 15:8. Samples leave each FIFO in the order they were written.
- R5: A channel pops only on an overflow of the timer it has selected. Select 0 follows tmr_ovf[0] and select 1 follows tmr_ovf[1].
- R6: A popped sample appears on the channel's sample output on the clock edge that accepts the overflow. It holds there until the next pop.
- R7: If a pop leaves 16 or fewer samples in the FIFO, refill_req for that channel is high for exactly the next cycle.
- R8: A pop that leaves more than 16 samples in the FIFO does not raise refill_req.
- R9: Each FIFO holds 32 bytes. Bytes pushed while it is full are dropped.
- R10: A pop from an empty FIFO outputs sample value 0. The FIFO stays empty.
- R11: Writing 1 to bit 11 (channel A) or bit 15 (channel B) of the control register empties that channel's FIFO. The same write also updates the stored control fields.
- R12: After reset the master enable, all control fields, both samples and both refill requests are zero, and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 master, 1 control, 2/3 FIFO A, 4/5 FIFO B) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational readback of the register at reg_addr |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 and timer 1 |
| sample_a | output | 8 | Held signed sample of channel A |
| sample_b | output | 8 | Held signed sample of channel B |
| refill_req | output | 2 | One-cycle refill request per channel (bit 0 = A) |
| route_left | output | 2 | Left routing enable per channel |
| route_right | output | 2 | Right routing enable per channel |
| vol_full | output | 2 | Volume select per channel (1 = full) |

## Verification
The bench uses the default parameters: a FIFO depth of 32 bytes and a low-water mark of 16. With these values, twenty two-byte writes are enough to reach the full boundary and show that the last eight bytes are dropped. Draining that full FIFO then passes the refill threshold, so the bench can see the last pop that stays silent and the first pop that raises a request. The shallow depth also keeps the empty-pop case a single step away from a drained queue.

// File: rtl/snd_chan_pkg.sv
// Package: register map and shared types for the timer-paced sample channel.
// Assumes two channels share one control register laid out with a stride of
// four bits per channel.
package snd_chan_pkg;

    localparam int unsigned NUM_CH    = 2;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned SMP_W     = 8;

    localparam logic [ADDR_W-1:0] A_MASTER = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;

    localparam int unsigned MASTER_BIT = 7;
    localparam int unsigned VOL_BIT    = 2;   // plus channel index
    localparam int unsigned RIGHT_BIT  = 8;   // plus CH_STRIDE * channel
    localparam int unsigned LEFT_BIT   = 9;
    localparam int unsigned TSEL_BIT   = 10;
    localparam int unsigned FLUSH_BIT  = 11;
    localparam int unsigned CH_STRIDE  = 4;

    typedef struct packed {
        logic vol_full;
        logic route_r;
        logic route_l;
        logic tsel;
    } chan_cfg_t;

endpackage

// File: rtl/snd_byte_fifo.sv
// Module: byte FIFO that can accept two bytes and release one byte per cycle.
// Assumes DEPTH is a power of two. A flush has priority over a same-cycle push.
// Bytes that do not fit are dropped, and a pop of an empty queue returns zero.
module snd_byte_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push2,
    input  logic [2*W-1:0]   din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] lvl_next
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] level, after_pop;
    logic             pop_eff, acc_lo, acc_hi;

    // Work out which pushes fit once this cycle's pop has been taken into account.
    always_comb begin
        pop_eff   = pop && (level != '0);
        after_pop = level - CNT_W'(pop_eff);
        acc_lo    = push2 && !flush && (after_pop < FULL);
        acc_hi    = push2 && !flush && ((after_pop + CNT_W'(acc_lo)) < FULL);
        lvl_next  = flush ? '0 : (after_pop + CNT_W'(acc_lo) + CNT_W'(acc_hi));
        dout      = (level != '0) ? mem[rd_ptr] : '0;
    end

    // Store the accepted bytes, low byte first.
    always_ff @(posedge clk) begin
        if (acc_lo) mem[wr_ptr] <= din[W-1:0];
        if (acc_hi) mem[wr_ptr + PTR_W'(acc_lo)] <= din[2*W-1:W];
    end

    // Update the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(acc_lo) + PTR_W'(acc_hi);
            rd_ptr <= rd_ptr + PTR_W'(pop_eff);
            level  <= lvl_next;
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);
    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    p_empty_pop_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (level == '0) && !push2 && !flush) |=> (level == '0));

endmodule

// File: rtl/snd_sample_chan.sv
// Module: one playback channel. It holds the FIFO, the output sample register
// and the refill pulse. Assumes that tick is already gated by the master
// enable and by the channel's timer choice.
module snd_sample_chan #(
    parameter int unsigned DEPTH     = 32,
    parameter int unsigned LOW_WATER = 16,
    parameter int unsigned W         = 8,
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           push,
    input  logic [2*W-1:0] push_data,
    input  logic           flush,
    output logic [W-1:0]   sample,
    output logic           refill
);

    localparam logic [CNT_W-1:0] LOW = CNT_W'(LOW_WATER);

    logic [W-1:0]     head;
    logic [CNT_W-1:0] lvl_next;

    snd_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push2    (push),
        .din      (push_data),
        .pop      (tick),
        .dout     (head),
        .lvl_next (lvl_next)
    );

    // On a pop, load the head sample and decide whether to ask for a refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
            refill <= 1'b0;
        end else begin
            refill <= tick && (lvl_next <= LOW);
            if (tick) sample <= head;
        end
    end

    p_refill_after_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refill |-> $past(tick));
    p_sample_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sample));

endmodule

// File: rtl/snd_ctl_regs.sv
// Module: register decode for the master enable, the shared control register
// and the FIFO ports. Assumes a single write per cycle. Flush bits are
// returned as one-cycle strobes and are not stored.
module snd_ctl_regs
    import snd_chan_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic                    master,
    output chan_cfg_t [NUM_CH-1:0]  cfg,
    output logic [NUM_CH-1:0]       flush,
    output logic [NUM_CH-1:0]       push,
    output logic [DATA_W-1:0]       rdata
);

    logic gated_wr;
    logic ctl_wr;
    logic [DATA_W-1:0] ctl_rd;

    assign gated_wr = wr && master && (addr != A_MASTER);
    assign ctl_wr   = gated_wr && (addr == A_CTRL);

    // Master enable: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                        master <= 1'b0;
        else if (wr && addr == A_MASTER)   master <= wdata[MASTER_BIT];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Per-channel stored fields of the control register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[c] <= '0;
            end else if (ctl_wr) begin
                cfg[c].vol_full <= wdata[VOL_BIT + c];
                cfg[c].route_r  <= wdata[RIGHT_BIT + CH_STRIDE*c];
                cfg[c].route_l  <= wdata[LEFT_BIT  + CH_STRIDE*c];
                cfg[c].tsel     <= wdata[TSEL_BIT  + CH_STRIDE*c];
            end
        end
        assign flush[c] = ctl_wr && wdata[FLUSH_BIT + CH_STRIDE*c];
        assign push[c]  = gated_wr && (addr[ADDR_W-1:1] == 2'(c + 1));
    end

    // Combinational readback. Flush bits are never stored, so they read as zero.
    always_comb begin
        ctl_rd = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ctl_rd[VOL_BIT + c]               = cfg[c].vol_full;
            ctl_rd[RIGHT_BIT + CH_STRIDE*c]   = cfg[c].route_r;
            ctl_rd[LEFT_BIT  + CH_STRIDE*c]   = cfg[c].route_l;
            ctl_rd[TSEL_BIT  + CH_STRIDE*c]   = cfg[c].tsel;
        end
        rdata = '0;
        if (addr == A_MASTER)    rdata[MASTER_BIT] = master;
        else if (addr == A_CTRL) rdata = ctl_rd;
    end

    p_master_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_MASTER) |=> (master == $past(wdata[MASTER_BIT])));
    p_ctrl_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !(wr && addr == A_MASTER)) |=> $stable(cfg));
    p_flush_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (flush == '0 && push == '0));

endmodule

// File: rtl/timer_sample_chan.sv
// Module: top level of the two-channel timer-paced sample player. Each
// channel follows the overflow of the timer it has selected, and only while
// the master enable is set. Assumes the overflow inputs are one-cycle pulses
// in the clk domain.
module timer_sample_chan
    import snd_chan_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 32,
    parameter int unsigned LOW_WATER  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [1:0]        tmr_ovf,
    output logic [7:0]        sample_a,
    output logic [7:0]        sample_b,
    output logic [1:0]        refill_req,
    output logic [1:0]        route_left,
    output logic [1:0]        route_right,
    output logic [1:0]        vol_full
);

    logic                   master;
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      flush, push, tick;
    logic [SMP_W-1:0]       smp [NUM_CH];

    snd_ctl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .master(master),
        .cfg   (cfg),
        .flush (flush),
        .push  (push),
        .rdata (reg_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign tick[c]        = master && tmr_ovf[cfg[c].tsel];
        assign route_left[c]  = cfg[c].route_l;
        assign route_right[c] = cfg[c].route_r;
        assign vol_full[c]    = cfg[c].vol_full;

        snd_sample_chan #(
            .DEPTH    (FIFO_DEPTH),
            .LOW_WATER(LOW_WATER),
            .W        (SMP_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[c]),
            .push     (push[c]),
            .push_data(reg_wdata),
            .flush    (flush[c]),
            .sample   (smp[c]),
            .refill   (refill_req[c])
        );
    end

    assign sample_a = smp[0];
    assign sample_b = smp[1];

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> (refill_req == '0));

endmodule

// File: tb/tb_timer_sample_chan.sv
module tb_timer_sample_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  tmr_ovf = '0;
    logic [7:0]  sample_a, sample_b;
    logic [1:0]  refill_req, route_left, route_right, vol_full;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    timer_sample_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf),
        .sample_a(sample_a), .sample_b(sample_b), .refill_req(refill_req),
        .route_left(route_left), .route_right(route_right), .vol_full(vol_full)
    );

    // Vector: addr(3) wr(1) data(16) ovf(2) expA(8) expB(8) expRefill(2)
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {3'd0, 1'b1, 16'h0080, 2'b00, 8'h00, 8'h00, 2'b00}, // master on
        {3'd1, 1'b1, 16'h6304, 2'b00, 8'h00, 8'h00, 2'b00}, // configure
        {3'd2, 1'b1, 16'h8211, 2'b00, 8'h00, 8'h00, 2'b00}, // R4 A: 11,82
        {3'd4, 1'b1, 16'h7FFE, 2'b00, 8'h00, 8'h00, 2'b00}, // R4 B: FE,7F
        {3'd0, 1'b0, 16'h0000, 2'b01, 8'h11, 8'h00, 2'b01}, // R5 timer0 -> A
        {3'd0, 1'b0, 16'h0000, 2'b10, 8'h11, 8'hFE, 2'b10}, // R5 timer1 -> B
        {3'd0, 1'b0, 16'h0000, 2'b11, 8'h82, 8'h7F, 2'b11}, // R4 order
        {3'd0, 1'b0, 16'h0000, 2'b01, 8'h00, 8'h7F, 2'b01}, // R10 empty pop
        {3'd3, 1'b1, 16'h5544, 2'b00, 8'h00, 8'h7F, 2'b00}, // R6 held
        {3'd0, 1'b0, 16'h0000, 2'b01, 8'h44, 8'h7F, 2'b01}  // R4 high-half addr
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] a, input logic w, input logic [15:0] d,
                        input logic [1:0] o);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; tmr_ovf = o;
        @(negedge clk);
        reg_wr = 1'b0; tmr_ovf = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 sample_a", {8'h0, sample_a}, 16'h0);
        chk("R12 sample_b", {8'h0, sample_b}, 16'h0);
        chk("R12 refill", {14'h0, refill_req}, 16'h0);
        step(3'd0, 1'b0, 16'h0, 2'b00);
        chk("R12 master readback", reg_rdata, 16'h0);

        // R2 everything ignored while master is off
        step(3'd1, 1'b1, 16'h6304, 2'b00);
        chk("R2 ctrl write ignored", reg_rdata, 16'h0);
        step(3'd2, 1'b1, 16'h3322, 2'b00);   // must not enter FIFO A
        step(3'd0, 1'b0, 16'h0, 2'b11);
        chk("R2 overflow ignored A", {8'h0, sample_a}, 16'h0);
        chk("R2 overflow ignored refill", {14'h0, refill_req}, 16'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][39:37], VEC[i][36], VEC[i][35:20], VEC[i][19:18]);
            chk($sformatf("R4/R5/R7 vec%0d sample_a", i), {8'h0, sample_a}, {8'h0, VEC[i][17:10]});
            chk($sformatf("R5/R6 vec%0d sample_b", i), {8'h0, sample_b}, {8'h0, VEC[i][9:2]});
            chk($sformatf("R7 vec%0d refill", i), {14'h0, refill_req}, {14'h0, VEC[i][1:0]});
        end

        // R1 master readback
        step(3'd0, 1'b0, 16'h0, 2'b00);
        chk("R1 master readback", reg_rdata, 16'h0080);

        // R3 readback and field outputs
        step(3'd1, 1'b0, 16'h0, 2'b00);
        chk("R3 ctrl readback", reg_rdata, 16'h6304);
        chk("R3 route_left", {14'h0, route_left}, 16'h3);
        chk("R3 route_right", {14'h0, route_right}, 16'h1);
        chk("R3 vol_full", {14'h0, vol_full}, 16'h1);

        // R11 flush A (0x55 pending), flush bit reads as zero
        step(3'd1, 1'b1, 16'h6B04, 2'b00);
        chk("R3 flush bit reads zero", reg_rdata, 16'h6304);
        step(3'd0, 1'b0, 16'h0, 2'b01);
        chk("R11 flushed pop gives zero", {8'h0, sample_a}, 16'h0);
        chk("R11 refill after flush", {14'h0, refill_req}, 16'h1);

        // R9 fill past capacity: bytes 0..39 offered, 0..31 kept
        for (int k = 0; k < 20; k++)
            step(3'd2, 1'b1, {8'(2*k + 1), 8'(2*k)}, 2'b00);
        for (int i = 0; i < 32; i++) begin
            step(3'd0, 1'b0, 16'h0, 2'b01);
            chk($sformatf("R9 drain byte %0d", i), {8'h0, sample_a}, 16'(i));
            chk((31 - i) <= 16 ? "R7 refill at low water" : "R8 no refill above low water",
                {14'h0, refill_req}, (31 - i) <= 16 ? 16'h1 : 16'h0);
        end
        step(3'd0, 1'b0, 16'h0, 2'b01);
        chk("R9 dropped bytes absent", {8'h0, sample_a}, 16'h0);
        chk("R10 empty pop refill", {14'h0, refill_req}, 16'h1);

        // R5 switch channel A to timer 1
        step(3'd1, 1'b1, 16'h6704, 2'b00);
        step(3'd2, 1'b1, 16'h6655, 2'b00);
        step(3'd0, 1'b0, 16'h0, 2'b01);
        chk("R5 timer0 no longer pops A", {8'h0, sample_a}, 16'h0);
        chk("R5 no refill on unselected", {14'h0, refill_req}, 16'h0);
        step(3'd0, 1'b0, 16'h0, 2'b10);
        chk("R5 timer1 pops A", {8'h0, sample_a}, 16'h55);
        chk("R10 B empty pop zero", {8'h0, sample_b}, 16'h0);
        chk("R7 both refill", {14'h0, refill_req}, 16'h3);

        // R2 master off again
        step(3'd0, 1'b1, 16'h0000, 2'b00);
        chk("R1 master cleared", reg_rdata, 16'h0);
        step(3'd0, 1'b0, 16'h0, 2'b11);
        chk("R2 sample held when off", {8'h0, sample_a}, 16'h55);
        chk("R2 no refill when off", {14'h0, refill_req}, 16'h0);
        step(3'd1, 1'b1, 16'h0000, 2'b00);
        chk("R2 ctrl kept when off", reg_rdata, 16'h6704);
        step(3'd0, 1'b1, 16'h0080, 2'b00);
        step(3'd0, 1'b0, 16'h0, 2'b10);
        chk("R2 FIFO kept 0x66", {8'h0, sample_a}, 16'h66);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule